// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models the slave side of a two-wire serial EEPROM. A host toggles the clock line and the data line. The block watches both lines, finds START and STOP conditions, and decodes the bytes that follow. It stores written bytes in an internal byte array and returns them on reads.

The addressing format is picked at run time through `mode_i`. The first format packs a 7-bit word address and the R/W flag into a single byte. The second sends a device byte, whose three low address bits give the upper part of an 11-bit address, and then one address byte. The third sends a device byte and then a high and a low address byte.

Two run-time masks set how addresses wrap. The size mask sets the memory capacity. The page mask sets which low address bits advance during a multi-byte write. A system clock oversamples both bus lines, and the block drives the data line only by pulling it low through `sda_oe_o`. No stream data crosses the block edge. Every pin is a plain control or line pin, so there is no valid/ready back-pressure.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0 and the block ignores bus activity until a START.
- R2: A START is SDA falling while SCL is high, and it begins a new address phase from any state, even in the middle of a byte; a partially received byte is discarded. A STOP is SDA rising while SCL is high; it returns the block to standby with SDA released.
- R3: With `mode_i` = 0, the first byte after START holds word address bits 6:0 in bits 7:1 and the R/W flag in bit 0 (1 = read, 0 = write).
- R4: With `mode_i` = 1, the first byte is the device byte. Its bits 7:4 must equal 4'b1010, bits 3:1 are address bits 10:8, and bit 0 is R/W. For a write, one byte with address bits 7:0 follows.
- R5: With `mode_i` = 2 or 3, the device byte (bits 7:4 = 4'b1010, bit 0 = R/W) is followed by address bits 15:8 and then by address bits 7:0.
- R6: Bytes are taken MSB first on SCL rising edges. The slave pulls SDA low during the ninth clock of every byte it accepts.
- R7: If the device byte's bits 7:4 differ from 4'b1010, the block gives no acknowledge, ignores all further bytes until STOP or START, and writes nothing.
- R8: In a write, each data byte is stored and the address then advances. Only the bits set in `page_mask_i` take part in the increment; the other bits keep their value.
- R9: In a read, the byte at the current address is driven MSB first, with each bit changing after an SCL fall. A device-byte read (modes 1 to 3) starts at the address left by the last access. After each master acknowledge, the address advances by one, wrapped by `size_mask_i`.
- R10: A master no-acknowledge ends the read. SDA stays released through any further clocks until STOP or START.
- R11: The storage location is the address ANDed with `size_mask_i`, so addresses beyond the capacity alias onto it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mode_i | input | 2 | Address format: 0 single byte, 1 device plus one byte, 2/3 device plus two bytes |
| size_mask_i | input | 16 | Capacity mask applied to every stored address |
| page_mask_i | input | 16 | Address bits that advance within a write page |

## Verification
The in-RTL assertions check properties that hold on every cycle. The data line stays released in standby and in wait-for-stop. A STOP always lands in standby and a START always lands in an address phase with a cleared bit count. The drive enable only moves on an SCL fall or a bus condition. A write never alters the address bits outside the page mask. Other behaviour can only be shown by the bench's scenarios, which compare bus traffic against a memory model. These are the byte decoding in the three formats, the contents read back, the page and capacity wraps, the silence after a device mismatch or a master no-acknowledge, and the discarding of a byte cut off by a START.

// File: rtl/tw_eeprom_pkg.sv
`timescale 1ns/1ps
package tw_eeprom_pkg;

  localparam int ADDR_W = 16;

  localparam logic [1:0] MODE_A7 = 2'd0;
  localparam logic [1:0] MODE_A8 = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_STOP,
    ST_DEV,
    ST_ADDR7,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WRITE,
    ST_READ
  } eep_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/tw_line_mon.sv
`timescale 1ns/1ps
module tw_line_mon
  import tw_eeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_q = scl_sh[SYNC_STAGES-1];
  assign sda_q = sda_sh[SYNC_STAGES-1];

  always_comb begin
    evt_o.rise  = scl_q & ~scl_p;
    evt_o.fall  = ~scl_q & scl_p;
    evt_o.start = scl_q & scl_p & sda_p & ~sda_q;
    evt_o.stop  = scl_q & scl_p & ~sda_p & sda_q;
    evt_o.sda   = sda_q;
  end

endmodule

// File: rtl/tw_byte_store.sv
`timescale 1ns/1ps
module tw_byte_store #(
  parameter int DEPTH = 2048,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/tw_eeprom_ctrl.sv
`timescale 1ns/1ps
module tw_eeprom_ctrl
  import tw_eeprom_pkg::*;
#(
  parameter int         IDX_W    = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] size_mask_i,
  input  logic [ADDR_W-1:0] page_mask_i,
  input  logic [7:0]        rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);

  eep_state_e        state, nxt_st;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [7:0]        txbyte;
  logic [ADDR_W-1:0] addr, nxt_addr;
  logic              nxt_ack;
  logic              active;

  assign active  = (state != ST_IDLE) && (state != ST_WAIT_STOP);
  assign mem_idx = addr[IDX_W-1:0] & size_mask_i[IDX_W-1:0];
  assign wr_data = shreg;
  assign wr_en   = evt.fall && !evt.start && !evt.stop &&
                   (bitcnt == 4'd8) && (state == ST_WRITE);

  // Decode of a completed byte, applied at the SCL fall that opens the ack slot
  always_comb begin
    nxt_st   = state;
    nxt_ack  = 1'b0;
    nxt_addr = addr;
    case (state)
      ST_ADDR7: begin
        nxt_ack  = 1'b1;
        nxt_addr = {{(ADDR_W-7){1'b0}}, shreg[7:1]};
        nxt_st   = shreg[0] ? ST_READ : ST_WRITE;
      end
      ST_DEV: begin
        if (shreg[7:4] != DEV_CODE) begin
          nxt_st = ST_WAIT_STOP;
        end else begin
          nxt_ack = 1'b1;
          if (shreg[0]) begin
            nxt_st = ST_READ;
          end else if (mode_i == MODE_A8) begin
            nxt_st   = ST_ADDR_LO;
            nxt_addr = {{(ADDR_W-11){1'b0}}, shreg[3:1], addr[7:0]};
          end else begin
            nxt_st = ST_ADDR_HI;
          end
        end
      end
      ST_ADDR_HI: begin
        nxt_ack  = 1'b1;
        nxt_addr = {shreg, addr[7:0]};
        nxt_st   = ST_ADDR_LO;
      end
      ST_ADDR_LO: begin
        nxt_ack  = 1'b1;
        nxt_addr = {addr[ADDR_W-1:8], shreg};
        nxt_st   = ST_WRITE;
      end
      ST_WRITE: begin
        nxt_ack  = 1'b1;
        nxt_addr = (addr & ~page_mask_i) |
                   (ADDR_W'(addr + 1'b1) & page_mask_i);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      shreg  <= 8'h00;
      txbyte <= 8'h00;
      addr   <= '0;
      sda_oe <= 1'b0;
    end else if (evt.start) begin
      state  <= (mode_i == MODE_A7) ? ST_ADDR7 : ST_DEV;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (evt.stop) begin
      state  <= ST_IDLE;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (evt.rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], evt.sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (state == ST_READ && evt.sda) state <= ST_WAIT_STOP;
        end
      end else if (evt.fall) begin
        if (bitcnt == 4'd8) begin
          if (state == ST_READ) begin
            sda_oe <= 1'b0;
            addr   <= ADDR_W'(addr + 1'b1) & size_mask_i;
          end else begin
            sda_oe <= nxt_ack;
            state  <= nxt_st;
            addr   <= nxt_addr;
          end
        end else if (bitcnt == 4'd9) begin
          bitcnt <= 4'd0;
          if (state == ST_READ) begin
            txbyte <= rd_data;
            sda_oe <= ~rd_data[7];
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (state == ST_READ && bitcnt != 4'd0) begin
          sda_oe <= ~txbyte[6];
          txbyte <= {txbyte[6:0], 1'b0};
        end
      end
    end
  end

  // R1: the line is released while the block is in standby
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R2: a STOP always lands in standby with the line released
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt.stop |=> (state == ST_IDLE) && !sda_oe);

  // R2: a START always lands in an address phase with a cleared count
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> ((state == ST_DEV) || (state == ST_ADDR7)) && (bitcnt == 4'd0));

  // R6: the drive enable moves only on an SCL fall or a bus condition
  a_r6_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(evt.fall || evt.start || evt.stop));

  // R6: the bit count stays within one byte plus the ack slot
  a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);

  // R7 / R10: nothing is driven while waiting for the STOP
  a_r7_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_STOP) |-> !sda_oe);

  // R8: a write never changes address bits outside the page mask
  a_r8_page_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((addr & ~$past(page_mask_i)) ==
               ($past(addr) & ~$past(page_mask_i))));

endmodule

// File: rtl/tw_eeprom_slave.sv
`timescale 1ns/1ps
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int         DEPTH       = 2048,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [1:0]  mode_i,
  input  logic [15:0] size_mask_i,
  input  logic [15:0] page_mask_i
);

  localparam int IDX_W = $clog2(DEPTH);

  bus_evt_t         evt;
  logic             wr_en;
  logic [IDX_W-1:0] mem_idx;
  logic [7:0]       wr_data;
  logic [7:0]       rd_data;

  tw_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt_o (evt)
  );

  tw_eeprom_ctrl #(.IDX_W(IDX_W), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .mode_i      (mode_i),
    .size_mask_i (size_mask_i),
    .page_mask_i (page_mask_i),
    .rd_data     (rd_data),
    .wr_en       (wr_en),
    .mem_idx     (mem_idx),
    .wr_data     (wr_data),
    .sda_oe      (sda_oe_o)
  );

  tw_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (mem_idx),
    .wr_data (wr_data),
    .rd_idx  (mem_idx),
    .rd_data (rd_data)
  );

endmodule

// File: tb/tw_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module tw_eeprom_slave_tb_top;

  localparam int P = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [1:0]  mode = 2'd0;
  logic [15:0] cfg_size = 16'h07FF;
  logic [15:0] cfg_page = 16'h000F;
  wire         sda_line = m_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] model [2048];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #2.5 clk = ~clk;

  tw_eeprom_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .mode_i      (mode),
    .size_mask_i (cfg_size),
    .page_mask_i (cfg_page)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] page_next(input logic [15:0] a);
    return (a & ~cfg_page) | ((a + 16'd1) & cfg_page);
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; tick(P);
    scl = 1'b1;   tick(P);
    m_sda = 1'b0; tick(P);
    scl = 1'b0;   tick(P);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(P);
    scl = 1'b1;   tick(P);
    m_sda = 1'b1; tick(P);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;  tick(P);
    scl = 1'b1; tick(P);
    scl = 1'b0; tick(P);
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(P);
    scl = 1'b1;   tick(P);
    acked = !sda_line;
    scl = 1'b0;   tick(P);
  endtask

  task automatic rx_byte(input bit last, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; tick(P);
      scl = 1'b1;   tick(P);
      b = {b[6:0], sda_line};
      scl = 1'b0;   tick(P);
    end
    m_sda = last; tick(P);
    scl = 1'b1;   tick(P);
    scl = 1'b0;   tick(P);
    m_sda = 1'b1;
  endtask

  // Sends the address header for a write in the current mode
  task automatic header_wr(input logic [15:0] a);
    bit ack;
    case (mode)
      2'd0: begin tx_byte({a[6:0], 1'b0}, ack); chk("R3 ack addr7", ack, 1); end
      2'd1: begin
        tx_byte({4'hA, a[10:8], 1'b0}, ack); chk("R4 ack dev", ack, 1);
        tx_byte(a[7:0], ack);                chk("R4 ack addr", ack, 1);
      end
      default: begin
        tx_byte(8'hA0, ack);      chk("R5 ack dev", ack, 1);
        tx_byte(a[15:8], ack);    chk("R5 ack hi", ack, 1);
        tx_byte(a[7:0], ack);     chk("R5 ack lo", ack, 1);
      end
    endcase
  endtask

  task automatic do_write(input logic [15:0] a, input int n);
    bit ack;
    logic [15:0] cur = a;
    bus_start();
    header_wr(a);
    for (int i = 0; i < n; i++) begin
      tx_byte(wbuf[i], ack);
      chk("R6 ack data", ack, 1);
      model[cur & cfg_size & 16'h07FF] = wbuf[i];
      cur = page_next(cur);
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    bit ack;
    bus_start();
    if (mode == 2'd0) begin
      tx_byte({a[6:0], 1'b1}, ack); chk("R3 ack read", ack, 1);
    end else begin
      header_wr(a);
      bus_start();
      tx_byte({4'hA, a[10:8], 1'b1}, ack); chk("R9 ack dev read", ack, 1);
    end
    for (int i = 0; i < n; i++) rx_byte(i == n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic check_read(input string req, input logic [15:0] a, input int n);
    logic [15:0] cur = a & cfg_size;
    do_read(a, n);
    for (int i = 0; i < n; i++) begin
      chk(req, rbuf[i], model[cur & 16'h07FF]);
      cur = (cur + 16'd1) & cfg_size;
    end
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int seed;
    for (int i = 0; i < 2048; i++) model[i] = 8'h00;
    seed = $urandom(32'h5EED1);
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 reset release", sda_oe, 0);

    // R3 + R8: single-byte address mode, page wrap with a 4-byte page
    mode = 2'd0; cfg_page = 16'h0003;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(16'h007E, 3);
    chk("R8 page wrap", model[16'h7C], 8'h33);
    check_read("R3 read 7bit", 16'h007C, 4);
    check_read("R9 seq read", 16'h007E, 4);

    // R4: 8-bit mode, upper bits from the device byte
    mode = 2'd1; cfg_page = 16'h000F;
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    do_write(16'h05F3, 2);
    check_read("R4 read 8bit", 16'h05F3, 2);

    // R5: 16-bit mode
    mode = 2'd2;
    wbuf[0] = 8'hC3;
    do_write(16'h0312, 1);
    check_read("R5 read 16bit", 16'h0312, 1);

    // R7: device mismatch gives no ack and writes nothing
    bus_start();
    tx_byte(8'h50, ack); chk("R7 no ack dev", ack, 0);
    tx_byte(8'h03, ack); chk("R7 no ack next", ack, 0);
    tx_byte(8'h12, ack); chk("R7 no ack data", ack, 0);
    bus_stop();
    check_read("R7 unchanged", 16'h0312, 1);

    // R10: master no-ack ends the read, later clocks see a released line
    bus_start();
    header_wr(16'h0312);
    bus_start();
    tx_byte(8'hA1, ack); chk("R9 ack dev read", ack, 1);
    rx_byte(1'b1, b);    chk("R10 data before nack", b, 8'hC3);
    rx_byte(1'b1, b);    chk("R10 released after nack", b, 8'hFF);
    bus_stop();

    // R2: START in the middle of a data byte discards it
    bus_start();
    header_wr(16'h0312);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    chk("R2 start releases", sda_oe, 0);
    bus_stop();
    chk("R2 stop releases", sda_oe, 0);
    check_read("R2 partial byte dropped", 16'h0312, 1);

    // R11: aliasing and read wrap under a 256-byte capacity
    cfg_size = 16'h00FF;
    wbuf[0] = 8'h5A;
    do_write(16'h0345, 1);
    chk("R11 alias model", model[16'h045], 8'h5A);
    check_read("R11 alias read", 16'h0045, 1);
    wbuf[0] = 8'hEE;
    do_write(16'h00FF, 1);
    check_read("R9 wrap at size", 16'h00FF, 2);
    cfg_size = 16'h07FF;

    // Random traffic across modes, pages and lengths
    for (int t = 0; t < 16; t++) begin
      logic [15:0] a;
      int n;
      mode = 2'($urandom());
      cfg_page = (16'h0001 << (2 + $urandom() % 3)) - 16'd1;
      a = 16'($urandom()) & ((mode == 2'd0) ? 16'h007F : 16'h07FF);
      n = 1 + $urandom() % 6;
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
      do_write(a, n);
      check_read("R8 random readback", a, n);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule